// File: doc/BRIEF.md
# Sv32 Privilege-Aware Page Permission Guard

This block sits beside a TLB and page-table walker in a 32-bit core with machine, supervisor and user modes. From the current privilege mode and the paging-enable bit of the address-translation register, it decides whether virtual addresses are translated. For each translated access it takes the access class (instruction fetch, load, or store/AMO) and the permission bits of the leaf page-table entry. It then reports whether that access must raise a page fault, and which fault cause applies.

The block also owns the machine status word, so it holds the supervisor-user-memory-access (SUM) bit. Software writes the word through a full machine view or through a masked supervisor view. The supervisor view exposes only the bits in its mask, and SUM is one of them. The stored SUM value feeds the permission decision directly. An S-mode kernel can therefore turn on access to user pages for its copy routines. Instruction fetches from user pages stay forbidden while SUM is set.

Top module: `sv32_perm_guard`

## Requirements
- R1: `xlate_on` is 1 exactly when `satp_mode` is 1 and `cur_priv` is not machine (3). Privilege encodings are U=0, S=1, M=3, and any other non-M value also translates.
- R2: In user mode (0), a translated access to an entry whose U bit (bit 4) is 0 faults, for every access class.
- R3: In supervisor mode (1), a translated instruction fetch from an entry with U=1 faults, whether SUM is 0 or 1.
- R4: In supervisor mode, a translated load or store to an entry with U=1 faults when SUM is 0. It is allowed when SUM is 1 and all other checks pass.
- R5: SUM is bit 18 of the status word. A write through either the machine view (`csr_is_sstatus`=0) or the supervisor view (`csr_is_sstatus`=1) sets or clears it, and the change shows on `mstatus_rdata` in the next cycle.
- R6: A supervisor-view write leaves every status bit outside the supervisor mask (default 0x000C0122) unchanged. `sstatus_rdata` always equals the status word ANDed with that mask.
- R7: An entry with A=0 (bit 6) faults on any access class. An entry with D=0 (bit 7) faults on a store but not on a fetch or load.
- R8: A fetch needs X=1 (bit 3), a load needs R=1 (bit 1) and a store needs W=1 (bit 2). Otherwise the access faults.
- R9: At most one of `flt_fetch`, `flt_load` and `flt_store` is high, matching `acc_kind` (0 fetch, 1 load, 2 store). `flt_cause` is 12, 13 or 15 for the respective fault and 0 when there is no fault.
- R10: When `xlate_on` is 0, when `acc_valid` is 0, or when `acc_kind` is 3, no fault is raised, whatever the entry bits.
- R11: A translated access to an entry with V=0 (bit 0), or with W=1 and R=0, faults.
- R12: After reset the status word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Status word write strobe |
| csr_is_sstatus | input | 1 | 1: write through supervisor view, 0: machine view |
| csr_wdata | input | 32 | Write data |
| mstatus_rdata | output | 32 | Machine view of the status word |
| sstatus_rdata | output | 32 | Supervisor view (masked) |
| cur_priv | input | 2 | Current privilege mode |
| satp_mode | input | 1 | Paging enable from the translation register |
| acc_valid | input | 1 | An access is being checked this cycle |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store/AMO, 3 none |
| pte_bits | input | 8 | Leaf entry flags D A G U X W R V (bit 7..0) |
| xlate_on | output | 1 | Translation is active |
| flt_fetch | output | 1 | Instruction page fault |
| flt_load | output | 1 | Load page fault |
| flt_store | output | 1 | Store/AMO page fault |
| flt_cause | output | 4 | Fault cause code, 0 if none |

## Verification
The assertions check on every cycle the relations that hold in every state. Machine mode and a disabled translation register never translate, and no fault appears without translation. Fault flags are one-hot. A supervisor fetch from a user page always faults. A user access to a supervisor page always faults. Each status write lands the written SUM bit and, through the supervisor view, keeps the unmasked bits. The bench scenarios cover what depends on a sequence of status writes followed by accesses. That means SUM being toggled and then consulted by loads and stores, the A/D and R/W/X combinations, and an exhaustive sweep of entry bits against a model built from the requirements.

// File: rtl/sv32_perm_pkg.sv
// Package: shared encodings for the Sv32 permission guard.
// Assumes the standard two-bit privilege encoding and leaf-entry flag layout
// used by the page-table walker that feeds this block.
package sv32_perm_pkg;
    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_H = 2'b10,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    // Leaf entry flag positions (decoded by the walker, so fixed)
    localparam int PTE_V = 0;
    localparam int PTE_R = 1;
    localparam int PTE_W = 2;
    localparam int PTE_X = 3;
    localparam int PTE_U = 4;
    localparam int PTE_G = 5;
    localparam int PTE_A = 6;
    localparam int PTE_D = 7;
    localparam int PTE_FLAGS = 8;

    localparam int N_CLASS = 3;
    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_IPF = 4'd12;
    localparam logic [CAUSE_W-1:0] CAUSE_LPF = 4'd13;
    localparam logic [CAUSE_W-1:0] CAUSE_SPF = 4'd15;

    localparam int SUM_BIT = 18;
endpackage

// File: rtl/status_sum_reg.sv
// Module: status_sum_reg
// Holds the machine status word. Writes come through the full machine view
// or the masked supervisor view; the supervisor view only touches bits in
// SMASK. Exposes the SUM bit to the permission logic.
// Assumes one write per cycle and a synchronous active-low reset to zero.
module status_sum_reg #(
    parameter int               XLEN  = 32,
    parameter logic [XLEN-1:0]  WMASK = '1,
    parameter logic [XLEN-1:0]  SMASK = 32'h000C_0122,
    parameter int               SUMB  = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            via_sview,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] m_view,
    output logic [XLEN-1:0] s_view,
    output logic            sum
);
    localparam logic [XLEN-1:0] S_WMASK = SMASK & WMASK;

    logic [XLEN-1:0] word_q;
    logic [XLEN-1:0] sel_mask;

    // Pick which bits this write may change
    always_comb sel_mask = via_sview ? S_WMASK : WMASK;

    // Store the status word with masked merge
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (we)
            word_q <= (word_q & ~sel_mask) | (wdata & sel_mask);
    end

    // Drive both views and the SUM tap
    always_comb begin
        m_view = word_q;
        s_view = word_q & SMASK;
        sum    = word_q[SUMB];
    end
endmodule

// File: rtl/xlate_gate.sv
// Module: xlate_gate
// Decides whether address translation is active: paging enabled and the
// hart is below machine mode (so supervisor and user both translate).
// Assumes the privilege input uses the package encoding.
module xlate_gate
    import sv32_perm_pkg::*;
(
    input  priv_e priv,
    input  logic  paging_en,
    output logic  active
);
    // Translation applies to every mode except machine
    always_comb active = paging_en && (priv != PRIV_M);
endmodule

// File: rtl/pte_perm_check.sv
// Module: pte_perm_check
// Combinational fault decision for one translated access. Each access class
// has its own lane (generated); a lane raises its fault only when the access
// is of that class. Checks validity, the R/W/X need, A/D state and the
// U-bit rule, where fetch ignores SUM and load/store honour it.
// Assumes the walker has already found a leaf entry; A/D are never set here.
module pte_perm_check
    import sv32_perm_pkg::*;
(
    input  logic                 active,
    input  logic                 valid,
    input  priv_e                priv,
    input  logic                 sum,
    input  acc_e                 kind,
    input  logic [PTE_FLAGS-1:0] pte,
    output logic [N_CLASS-1:0]   fault,
    output logic [CAUSE_W-1:0]   cause
);
    logic malformed;
    logic user_pg;

    // Entry-level checks shared by every class
    always_comb begin
        malformed = !pte[PTE_V] || (pte[PTE_W] && !pte[PTE_R]) || !pte[PTE_A];
        user_pg   = pte[PTE_U];
    end

    for (genvar c = 0; c < N_CLASS; c++) begin : g_lane
        logic need_bit;
        logic dirty_bad;
        logic priv_bad;
        logic is_mine;

        // Per-class permission, dirty and privilege rules
        always_comb begin
            is_mine   = (kind == acc_e'(c));
            need_bit  = (c == int'(ACC_FETCH)) ? pte[PTE_X] :
                        (c == int'(ACC_LOAD))  ? pte[PTE_R] : pte[PTE_W];
            dirty_bad = (c == int'(ACC_STORE)) && !pte[PTE_D];
            if (priv == PRIV_U)
                priv_bad = !user_pg;
            else if (c == int'(ACC_FETCH))
                priv_bad = user_pg;
            else
                priv_bad = user_pg && !sum;
            fault[c] = active && valid && is_mine &&
                       (malformed || !need_bit || dirty_bad || priv_bad);
        end
    end

    // Encode the cause code of the faulting class
    always_comb begin
        if (fault[ACC_FETCH])      cause = CAUSE_IPF;
        else if (fault[ACC_LOAD])  cause = CAUSE_LPF;
        else if (fault[ACC_STORE]) cause = CAUSE_SPF;
        else                       cause = '0;
    end
endmodule

// File: rtl/sv32_perm_guard.sv
// Module: sv32_perm_guard (top)
// Ties together the status word (with SUM), the translation gate and the
// per-access permission checker. Fault outputs are combinational on the
// access inputs; only the status word is registered.
// Assumes the caller presents one access per cycle with its leaf flags.
module sv32_perm_guard
    import sv32_perm_pkg::*;
#(
    parameter int              XLEN          = 32,
    parameter logic [XLEN-1:0] MSTATUS_WMASK = '1,
    parameter logic [XLEN-1:0] SSTATUS_MASK  = 32'h000C_0122
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic            csr_is_sstatus,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] mstatus_rdata,
    output logic [XLEN-1:0] sstatus_rdata,
    input  logic [1:0]      cur_priv,
    input  logic            satp_mode,
    input  logic            acc_valid,
    input  logic [1:0]      acc_kind,
    input  logic [7:0]      pte_bits,
    output logic            xlate_on,
    output logic            flt_fetch,
    output logic            flt_load,
    output logic            flt_store,
    output logic [3:0]      flt_cause
);
    logic               sum_bit;
    logic [N_CLASS-1:0] flt_vec;
    priv_e              priv_t;
    acc_e               kind_t;

    // Cast raw port values to package types
    always_comb begin
        priv_t = priv_e'(cur_priv);
        kind_t = acc_e'(acc_kind);
    end

    status_sum_reg #(
        .XLEN (XLEN),
        .WMASK(MSTATUS_WMASK),
        .SMASK(SSTATUS_MASK),
        .SUMB (SUM_BIT)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (csr_we),
        .via_sview(csr_is_sstatus),
        .wdata    (csr_wdata),
        .m_view   (mstatus_rdata),
        .s_view   (sstatus_rdata),
        .sum      (sum_bit)
    );

    xlate_gate u_gate (
        .priv     (priv_t),
        .paging_en(satp_mode),
        .active   (xlate_on)
    );

    pte_perm_check u_chk (
        .active(xlate_on),
        .valid (acc_valid),
        .priv  (priv_t),
        .sum   (sum_bit),
        .kind  (kind_t),
        .pte   (pte_bits),
        .fault (flt_vec),
        .cause (flt_cause)
    );

    // Break the fault vector out per class
    always_comb begin
        flt_fetch = flt_vec[ACC_FETCH];
        flt_load  = flt_vec[ACC_LOAD];
        flt_store = flt_vec[ACC_STORE];
    end
endmodule

// File: rtl/sv32_perm_guard_chk.sv
// Module: sv32_perm_guard_chk
// Property checker bound onto sv32_perm_guard. Observes ports only.
module sv32_perm_guard_chk #(
    parameter logic [31:0] SMASK = 32'h000C_0122
) (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_we,
    input logic        csr_is_sstatus,
    input logic [31:0] csr_wdata,
    input logic [31:0] mstatus_rdata,
    input logic [1:0]  cur_priv,
    input logic        satp_mode,
    input logic        acc_valid,
    input logic [1:0]  acc_kind,
    input logic [7:0]  pte_bits,
    input logic        xlate_on,
    input logic        flt_fetch,
    input logic        flt_load,
    input logic        flt_store
);
    a_r1_mmode_bare: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == 2'b11 || !satp_mode) |-> !xlate_on);

    a_r1_lower_xlate: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv != 2'b11 && satp_mode) |-> xlate_on);

    a_r2_user_on_spage: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && xlate_on && cur_priv == 2'b00 && !pte_bits[4] && acc_kind != 2'd3)
        |-> (flt_fetch || flt_load || flt_store));

    a_r3_sfetch_upage: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && xlate_on && cur_priv == 2'b01 && acc_kind == 2'd0 && pte_bits[4])
        |-> flt_fetch);

    a_r5_sum_lands: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> (mstatus_rdata[18] == $past(csr_wdata[18])));

    a_r6_keep_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_is_sstatus)
        |=> ((mstatus_rdata & ~SMASK) == ($past(mstatus_rdata) & ~SMASK)));

    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flt_fetch, flt_load, flt_store}));

    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlate_on || !acc_valid || acc_kind == 2'd3)
        |-> !(flt_fetch || flt_load || flt_store));
endmodule

bind sv32_perm_guard sv32_perm_guard_chk #(.SMASK(SSTATUS_MASK)) u_prop (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_we        (csr_we),
    .csr_is_sstatus(csr_is_sstatus),
    .csr_wdata     (csr_wdata),
    .mstatus_rdata (mstatus_rdata),
    .cur_priv      (cur_priv),
    .satp_mode     (satp_mode),
    .acc_valid     (acc_valid),
    .acc_kind      (acc_kind),
    .pte_bits      (pte_bits),
    .xlate_on      (xlate_on),
    .flt_fetch     (flt_fetch),
    .flt_load      (flt_load),
    .flt_store     (flt_store)
);

// File: tb/sim_sv32_perm_guard.sv
`timescale 1ns/1ps
module sim_sv32_perm_guard;
    localparam logic [31:0] SMASK = 32'h000C_0122;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic        csr_is_sstatus = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] mstatus_rdata, sstatus_rdata;
    logic [1:0]  cur_priv = 2'b11;
    logic        satp_mode = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'd3;
    logic [7:0]  pte_bits = '0;
    logic        xlate_on, flt_fetch, flt_load, flt_store;
    logic [3:0]  flt_cause;

    int checks = 0;
    int errors = 0;
    bit sum_m = 1'b0;

    always #2.5 clk = ~clk;

    sv32_perm_guard u0 (.*);

    // Flag bits: D A G U X W R V
    localparam logic [7:0] F_V = 8'h01, F_R = 8'h02, F_W = 8'h04, F_X = 8'h08;
    localparam logic [7:0] F_U = 8'h10, F_A = 8'h40, F_D = 8'h80;
    localparam logic [7:0] FULL = F_V | F_R | F_W | F_X | F_A | F_D;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected fault vector {store,load,fetch} from the requirements
    function automatic logic [2:0] model(input logic [1:0] p, input logic sm,
                                         input logic s, input logic v,
                                         input logic [1:0] k, input logic [7:0] f);
        logic bad;
        if (!(sm && p != 2'b11) || !v || k == 2'd3) return 3'b000;
        bad = !f[0] || (f[2] && !f[1]) || !f[6];                     // R11, R7
        case (k)
            2'd0: bad = bad || !f[3];                                // R8
            2'd1: bad = bad || !f[1];
            default: bad = bad || !f[2] || !f[7];
        endcase
        if (p == 2'b00) bad = bad || !f[4];                          // R2
        else if (k == 2'd0) bad = bad || f[4];                       // R3
        else bad = bad || (f[4] && !s);                              // R4
        return bad ? (3'b001 << k) : 3'b000;
    endfunction

    task automatic csr_write(input logic sview, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_is_sstatus = sview; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
        sum_m = mstatus_rdata[18];
    endtask

    task automatic access(input logic [1:0] p, input logic [1:0] k, input logic [7:0] f);
        @(negedge clk);
        cur_priv = p; satp_mode = 1'b1; acc_valid = 1'b1; acc_kind = k; pte_bits = f;
        #1;
    endtask

    function automatic logic [2:0] got();
        return {flt_store, flt_load, flt_fetch};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R12 mstatus reset", mstatus_rdata, 32'h0);
        chk("R12 sstatus reset", sstatus_rdata, 32'h0);
    endtask

    task automatic t_xlate();
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
                @(negedge clk);
                cur_priv = 2'(p); satp_mode = 1'(s); acc_valid = 1'b0;
                #1;
                chk("R1 xlate_on", {31'b0, xlate_on}, {31'b0, (s == 1) && (p != 3)});
            end
        end
    endtask

    task automatic t_user();
        for (int k = 0; k < 3; k++) begin
            access(2'b00, 2'(k), FULL);
            chk("R2 user on supervisor page", {29'b0, got()}, {29'b0, 3'b001 << k});
            access(2'b00, 2'(k), FULL | F_U);
            chk("R2 user on user page", {29'b0, got()}, 32'h0);
        end
    endtask

    task automatic t_sfetch();
        csr_write(1'b1, 32'h0);
        access(2'b01, 2'd0, FULL | F_U);
        chk("R3 sfetch upage SUM=0", {31'b0, flt_fetch}, 32'h1);
        csr_write(1'b1, 32'h0004_0000);
        access(2'b01, 2'd0, FULL | F_U);
        chk("R3 sfetch upage SUM=1", {31'b0, flt_fetch}, 32'h1);
    endtask

    task automatic t_sum_ls();
        csr_write(1'b0, 32'h0);
        access(2'b01, 2'd1, FULL | F_U);
        chk("R4 sload upage SUM=0", {31'b0, flt_load}, 32'h1);
        access(2'b01, 2'd2, FULL | F_U);
        chk("R4 sstore upage SUM=0", {31'b0, flt_store}, 32'h1);
        csr_write(1'b1, 32'h0004_0000);
        access(2'b01, 2'd1, FULL | F_U);
        chk("R4 sload upage SUM=1", {29'b0, got()}, 32'h0);
        access(2'b01, 2'd2, FULL | F_U);
        chk("R4 sstore upage SUM=1", {29'b0, got()}, 32'h0);
    endtask

    task automatic t_csr();
        csr_write(1'b1, 32'h0004_0000);
        chk("R5 sstatus sets SUM", {31'b0, mstatus_rdata[18]}, 32'h1);
        csr_write(1'b1, 32'h0);
        chk("R5 sstatus clears SUM", {31'b0, mstatus_rdata[18]}, 32'h0);
        csr_write(1'b0, 32'h0004_0000);
        chk("R5 mstatus sets SUM", {31'b0, mstatus_rdata[18]}, 32'h1);
        csr_write(1'b0, 32'hFFFF_FFFF);
        csr_write(1'b1, 32'h0);
        chk("R6 unmasked bits kept", mstatus_rdata, ~SMASK);
        chk("R6 sstatus view", sstatus_rdata, 32'h0);
        csr_write(1'b1, 32'hFFFF_FFFF);
        chk("R6 sstatus view masked", sstatus_rdata, SMASK);
        chk("R6 full word", mstatus_rdata, 32'hFFFF_FFFF);
        csr_write(1'b0, 32'h0);
    endtask

    task automatic t_ad();
        for (int k = 0; k < 3; k++) begin
            access(2'b01, 2'(k), FULL & ~F_A);
            chk("R7 A=0 faults", {29'b0, got()}, {29'b0, 3'b001 << k});
            access(2'b01, 2'(k), FULL & ~F_D);
            chk("R7 D=0", {29'b0, got()}, (k == 2) ? 32'h4 : 32'h0);
        end
    endtask

    task automatic t_rwx();
        access(2'b01, 2'd0, FULL & ~F_X);
        chk("R8 fetch needs X", {31'b0, flt_fetch}, 32'h1);
        access(2'b01, 2'd1, F_V | F_X | F_A | F_D);
        chk("R8 load needs R", {31'b0, flt_load}, 32'h1);
        access(2'b01, 2'd2, F_V | F_R | F_A | F_D);
        chk("R8 store needs W", {31'b0, flt_store}, 32'h1);
        access(2'b01, 2'd1, F_V | F_R | F_A);
        chk("R8 load with R ok", {29'b0, got()}, 32'h0);
    endtask

    task automatic t_cause();
        access(2'b00, 2'd0, FULL);
        chk("R9 fetch cause", {28'b0, flt_cause}, 32'd12);
        access(2'b00, 2'd1, FULL);
        chk("R9 load cause", {28'b0, flt_cause}, 32'd13);
        access(2'b00, 2'd2, FULL);
        chk("R9 store cause", {28'b0, flt_cause}, 32'd15);
        access(2'b00, 2'd1, FULL | F_U);
        chk("R9 no-fault cause", {28'b0, flt_cause}, 32'd0);
    endtask

    task automatic t_quiet();
        access(2'b00, 2'd3, 8'h00);
        chk("R10 kind none", {29'b0, got()}, 32'h0);
        @(negedge clk); acc_kind = 2'd0; acc_valid = 1'b0; #1;
        chk("R10 not valid", {29'b0, got()}, 32'h0);
        @(negedge clk); acc_valid = 1'b1; satp_mode = 1'b0; #1;
        chk("R10 paging off", {29'b0, got()}, 32'h0);
        @(negedge clk); satp_mode = 1'b1; cur_priv = 2'b11; #1;
        chk("R10 machine mode", {29'b0, got()}, 32'h0);
    endtask

    task automatic t_malformed();
        access(2'b01, 2'd1, FULL & ~F_V);
        chk("R11 V=0", {31'b0, flt_load}, 32'h1);
        access(2'b01, 2'd2, F_V | F_W | F_A | F_D);
        chk("R11 W without R", {31'b0, flt_store}, 32'h1);
    endtask

    task automatic t_sweep();
        for (int s = 0; s < 2; s++) begin
            csr_write(1'b0, s ? 32'h0004_0000 : 32'h0);
            for (int p = 0; p < 4; p++)
                for (int k = 0; k < 4; k++)
                    for (int f = 0; f < 256; f++) begin
                        access(2'(p), 2'(k), 8'(f));
                        chk("R2 R3 R4 R7 R8 R11 sweep", {29'b0, got()},
                            {29'b0, model(2'(p), 1'b1, sum_m, 1'b1, 2'(k), 8'(f))});
                    end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_xlate();
        t_user();
        t_sfetch();
        t_sum_ls();
        t_csr();
        t_ad();
        t_rwx();
        t_cause();
        t_quiet();
        t_malformed();
        t_sweep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule